// File: doc/BRIEF.md
# Ferroelectric Memory Identification Sequencer

This block runs a short identification routine against a ferroelectric serial memory after each start pulse. It sends the device-identification command, collects the nine-byte reply, and checks the manufacturer byte. It turns the density code in the reply into a memory size in bytes and an address length of two or three bytes. When the reply reports that a serial number is present, it issues a second command and gathers eight serial-number bytes. It presents them with their byte order reversed.

The block does not shift bits itself. It hands one byte at a time to an external SPI byte engine and owns only the chip-select line. The result is reported on a pair of mutually exclusive flags, valid and error, with the decoded size, address length and serial number beside them. Those outputs remain steady until the next accepted start.

Byte handshake rules: the sequencer holds `bx_req` high with `bx_tx` stable until the engine answers. A byte is complete in any clock cycle in which `bx_req` and `bx_done` are both high. In that cycle `bx_rx` carries the byte received during the transfer. The engine may wait any number of cycles before it raises `bx_done`, so it sets the pace. It must not assert `bx_done` while `bx_req` is low.

Top module: `fram_probe`

## Requirements
- R1: An accepted start opens a frame with chip select low. The frame carries the opcode 0x9F followed by exactly 9 read transfers, each sending 0x00. Chip select then returns high.
- R2: Reply byte 6 (zero-based, counted after the opcode) must be 0xC2. Any other value ends the probe with `id_error` set.
- R3: Reply byte 7 is a density code that is accepted only in the range 0x21 to 0x26 inclusive. Any other code ends the probe with `id_error` set.
- R4: On success, `mem_bytes` equals 2 to the power (code − 0x21 + 14), which gives 16384 up to 524288.
- R5: On success, `addr_bytes` is 3 when `mem_bytes` exceeds 65536 and 2 otherwise.
- R6: On success, if reply byte 8 is nonzero, a second frame follows with chip select high in between. It carries opcode 0xC3 followed by exactly 8 read transfers. If reply byte 8 is zero, no second frame is issued and `serial` is zero.
- R7: Byte i of `serial` (bits 8i+7 down to 8i) equals the (7−i)-th byte received in the serial-number frame, counted from 0.
- R8: `id_valid` and `id_error` are never high together. Both clear when a start is accepted, and the value reached holds until the next accepted start.
- R9: On an error, no serial-number frame is issued, and `mem_bytes`, `addr_bytes` and `serial` are zero.
- R10: A start pulse that arrives while a probe is in progress is ignored. The running probe finishes unchanged.
- R11: While `bx_req` is high and `bx_done` is low, the next cycle still has `bx_req` high with `bx_tx` unchanged. `bx_req` is high only while chip select is low.
- R12: After reset, chip select is high, `bx_req` is low, and `id_valid` and `id_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a probe when idle |
| bx_done | input | 1 | Byte engine completion, paired with `bx_req` |
| bx_rx | input | 8 | Byte received during the completing transfer |
| bx_req | output | 1 | Byte transfer request, held until completion |
| bx_tx | output | 8 | Byte to send |
| spi_cs_n | output | 1 | Active-low chip select of the memory |
| id_valid | output | 1 | Identification succeeded |
| id_error | output | 1 | Identification failed |
| mem_bytes | output | 20 | Decoded memory size in bytes |
| addr_bytes | output | 2 | Address length in bytes (2 or 3) |
| serial | output | 64 | Serial number, byte order reversed |

## Verification
The bench sweeps all 256 density codes. It mixes in corrupted manufacturer bytes, which separates the range check from the manufacturer check and covers both ends of the accepted range. The serial-present byte alternates between zero and a variety of nonzero values, so the runs with one frame can be told apart from the runs with two. Serial patterns differ from one byte position to the next, so a wrong byte order gives a mismatch. Engine latencies of 0 to 2 extra cycles exercise the held-request rules. Some runs carry a second start in mid-probe to show that it is ignored.

// File: rtl/fprobe_pkg.sv
package fprobe_pkg;
  localparam int ID_BYTES  = 9;
  localparam int SN_BYTES  = 8;
  localparam int MFR_POS   = 6;
  localparam int DENS_POS  = 7;
  localparam int FLAG_POS  = 8;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_SN    = 8'hC3;
  localparam logic [7:0] MFR_CODE = 8'hC2;
  localparam logic [7:0] DENS_LO  = 8'h21;
  localparam logic [7:0] DENS_HI  = 8'h26;
  localparam logic [7:0] FILL     = 8'h00;
  localparam int MIN_LOG2  = 14;
  localparam int WIDE_LOG2 = 16;
  localparam int SIZE_W    = MIN_LOG2 + int'(DENS_HI - DENS_LO) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID_CMD, ST_ID_RD, ST_CHECK, ST_SN_CMD, ST_SN_RD
  } pst_e;
endpackage

// File: rtl/fprobe_seq.sv
module fprobe_seq
  import fprobe_pkg::*;
#(
  parameter int IDN = ID_BYTES,
  parameter int SNN = SN_BYTES,
  localparam int CW = $clog2(IDN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bx_done,
  input  logic          chk_ok,
  input  logic          sn_want,
  output logic          spi_cs_n,
  output logic          bx_req,
  output logic [7:0]    bx_tx,
  output logic          rd_fire,
  output logic [CW-1:0] rd_idx,
  output logic          rd_sn,
  output logic          probe_clr,
  output logic          fin_ok,
  output logic          fin_err
);
  pst_e          st;
  logic [CW-1:0] cnt;
  logic          fire;

  always_comb begin
    bx_req    = (st == ST_ID_CMD) || (st == ST_ID_RD) ||
                (st == ST_SN_CMD) || (st == ST_SN_RD);
    spi_cs_n  = !bx_req;
    bx_tx     = (st == ST_ID_CMD) ? OP_ID : (st == ST_SN_CMD) ? OP_SN : FILL;
    fire      = bx_req && bx_done;
    rd_fire   = fire && ((st == ST_ID_RD) || (st == ST_SN_RD));
    rd_sn     = (st == ST_SN_RD);
    rd_idx    = cnt;
    probe_clr = start && (st == ST_IDLE);
    fin_err   = (st == ST_CHECK) && !chk_ok;
    fin_ok    = ((st == ST_CHECK) && chk_ok && !sn_want) ||
                ((st == ST_SN_RD) && fire && (cnt == CW'(SNN - 1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:   if (start) begin st <= ST_ID_CMD; cnt <= '0; end
        ST_ID_CMD: if (fire) begin st <= ST_ID_RD; cnt <= '0; end
        ST_ID_RD:
          if (fire) begin
            if (cnt == CW'(IDN - 1)) st <= ST_CHECK;
            else cnt <= cnt + 1'b1;
          end
        ST_CHECK:
          if (!chk_ok) st <= ST_IDLE;
          else if (sn_want) st <= ST_SN_CMD;
          else st <= ST_IDLE;
        ST_SN_CMD: if (fire) begin st <= ST_SN_RD; cnt <= '0; end
        ST_SN_RD:
          if (fire) begin
            if (cnt == CW'(SNN - 1)) st <= ST_IDLE;
            else cnt <= cnt + 1'b1;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_req && !bx_done) |=> (bx_req && $stable(bx_tx)));
  // R11
  cs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bx_req |-> !spi_cs_n);
  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (int'(rd_idx) < IDN));
endmodule

// File: rtl/fprobe_idcap.sv
module fprobe_idcap
  import fprobe_pkg::*;
#(
  parameter int IDN = ID_BYTES,
  parameter int SW  = SIZE_W,
  localparam int CW = $clog2(IDN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [CW-1:0] cap_idx,
  input  logic [7:0]    din,
  output logic          chk_ok,
  output logic          sn_want,
  output logic [SW-1:0] size_bytes,
  output logic [1:0]    addr_len
);
  logic [7:0] mfr_q, dens_q, flag_q;
  logic [7:0] shamt;
  logic       in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mfr_q  <= '0;
      dens_q <= '0;
      flag_q <= '0;
    end else if (cap_en) begin
      if (cap_idx == CW'(MFR_POS))  mfr_q  <= din;
      if (cap_idx == CW'(DENS_POS)) dens_q <= din;
      if (cap_idx == CW'(FLAG_POS)) flag_q <= din;
    end
  end

  always_comb begin
    in_range   = (dens_q >= DENS_LO) && (dens_q <= DENS_HI);
    chk_ok     = (mfr_q == MFR_CODE) && in_range;
    sn_want    = (flag_q != 8'h00);
    shamt      = dens_q - DENS_LO + 8'(MIN_LOG2);
    size_bytes = chk_ok ? (SW'(1) << shamt) : '0;
    if (!chk_ok) addr_len = 2'd0;
    else if (size_bytes > SW'(1 << WIDE_LOG2)) addr_len = 2'd3;
    else addr_len = 2'd2;
  end
endmodule

// File: rtl/fprobe_snreg.sv
module fprobe_snreg #(
  parameter int SNN = 8,
  localparam int QW = 8 * SNN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic [7:0]    din,
  output logic [QW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (shift_en) q <= {q[QW-9:0], din};
  end
endmodule

// File: rtl/fram_probe.sv
module fram_probe
  import fprobe_pkg::*;
#(
  parameter int IDN = ID_BYTES,
  parameter int SNN = SN_BYTES,
  parameter int SW  = SIZE_W,
  localparam int CW = $clog2(IDN + 1),
  localparam int QW = 8 * SNN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bx_done,
  input  logic [7:0]    bx_rx,
  output logic          bx_req,
  output logic [7:0]    bx_tx,
  output logic          spi_cs_n,
  output logic          id_valid,
  output logic          id_error,
  output logic [SW-1:0] mem_bytes,
  output logic [1:0]    addr_bytes,
  output logic [QW-1:0] serial
);
  logic          chk_ok, sn_want, rd_fire, rd_sn, probe_clr, fin_ok, fin_err;
  logic [CW-1:0] rd_idx;
  logic [SW-1:0] dec_size;
  logic [1:0]    dec_addr;

  fprobe_seq #(.IDN(IDN), .SNN(SNN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bx_done(bx_done),
    .chk_ok(chk_ok), .sn_want(sn_want), .spi_cs_n(spi_cs_n),
    .bx_req(bx_req), .bx_tx(bx_tx), .rd_fire(rd_fire), .rd_idx(rd_idx),
    .rd_sn(rd_sn), .probe_clr(probe_clr), .fin_ok(fin_ok), .fin_err(fin_err)
  );

  fprobe_idcap #(.IDN(IDN), .SW(SW)) u_idcap (
    .clk(clk), .rst_n(rst_n), .cap_en(rd_fire && !rd_sn), .cap_idx(rd_idx),
    .din(bx_rx), .chk_ok(chk_ok), .sn_want(sn_want),
    .size_bytes(dec_size), .addr_len(dec_addr)
  );

  fprobe_snreg #(.SNN(SNN)) u_snreg (
    .clk(clk), .rst_n(rst_n), .clr(probe_clr), .shift_en(rd_fire && rd_sn),
    .din(bx_rx), .q(serial)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || probe_clr) begin
      id_valid   <= 1'b0;
      id_error   <= 1'b0;
      mem_bytes  <= '0;
      addr_bytes <= '0;
    end else if (fin_ok) begin
      id_valid   <= 1'b1;
      mem_bytes  <= dec_size;
      addr_bytes <= dec_addr;
    end else if (fin_err) begin
      id_error   <= 1'b1;
    end
  end

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && id_error));
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !start) |=> id_valid);
  // R5
  addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> ((addr_bytes == 2'd3) == (int'(mem_bytes) > 65536)));
  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |-> (serial == '0 && mem_bytes == '0 && addr_bytes == 2'd0));
endmodule

// File: tb/fram_probe_bench.sv
module fram_probe_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bx_done, bx_req, spi_cs_n, id_valid, id_error;
  logic [7:0] bx_rx, bx_tx;
  logic [19:0] mem_bytes;
  logic [1:0] addr_bytes;
  logic [63:0] serial;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  fram_probe u_fram_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .bx_done(bx_done), .bx_rx(bx_rx),
    .bx_req(bx_req), .bx_tx(bx_tx), .spi_cs_n(spi_cs_n), .id_valid(id_valid),
    .id_error(id_error), .mem_bytes(mem_bytes), .addr_bytes(addr_bytes),
    .serial(serial)
  );

  // memory-side model
  logic [7:0] idb [16];
  logic [7:0] snb [16];
  logic [7:0] fop [4];
  int flen [4];
  logic [7:0] cur_op;
  int pos, wt, nfr, lat;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos <= 0; wt <= 0; nfr <= 0; bx_done <= 1'b0; bx_rx <= 8'h00; cur_op <= 8'h00;
    end else if (spi_cs_n) begin
      bx_done <= 1'b0;
      wt <= 0;
      if (pos != 0) begin
        fop[nfr % 4]  <= cur_op;
        flen[nfr % 4] <= pos;
        nfr <= nfr + 1;
        pos <= 0;
      end
    end else begin
      bx_done <= 1'b0;
      if (bx_req && !bx_done) begin
        if (wt >= lat) begin
          bx_done <= 1'b1;
          wt <= 0;
          pos <= pos + 1;
          if (pos == 0) begin
            cur_op <= bx_tx;
            bx_rx  <= 8'h00;
          end else if (cur_op == 8'h9F) bx_rx <= idb[pos-1];
          else if (cur_op == 8'hC3) bx_rx <= snb[pos-1];
          else bx_rx <= 8'h00;
        end else wt <= wt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] code, input logic [7:0] mfr,
                         input logic [7:0] flag, input int lat_i, input bit extra);
    bit ok;
    int base, expfr, wd;
    logic [19:0] esize;
    logic [1:0] eaddr;
    logic [63:0] esn;
    for (int k = 0; k < 16; k++) begin
      idb[k] = 8'(k * 17) ^ code;
      snb[k] = code ^ 8'(k * 37 + 11) ^ 8'h5A;
    end
    idb[6] = mfr; idb[7] = code; idb[8] = flag;
    lat  = lat_i;
    base = nfr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wd = 0;
    while (!(id_valid || id_error) && wd < 600) begin
      @(negedge clk); wd++;
    end
    repeat (3) @(negedge clk);
    ok    = (mfr == 8'hC2) && (code >= 8'h21) && (code <= 8'h26);
    esize = ok ? (20'd1 << (code - 8'h21 + 8'd14)) : 20'd0;
    eaddr = !ok ? 2'd0 : (code >= 8'h24 ? 2'd3 : 2'd2);
    esn   = '0;
    if (ok && flag != 8'h00)
      for (int i = 0; i < 8; i++) esn[8*i +: 8] = snb[7-i];
    expfr = (ok && flag != 8'h00) ? 2 : 1;
    chk("R2_R3 valid flag", 64'(id_valid), 64'(ok));
    chk("R2_R3 error flag", 64'(id_error), 64'(!ok));
    chk("R4 size", 64'(mem_bytes), 64'(esize));
    chk("R5 addr bytes", 64'(addr_bytes), 64'(eaddr));
    chk("R7 serial", serial, esn);
    chk("R6_R9_R10 frame count", 64'(nfr - base), 64'(expfr));
    chk("R1 id opcode", 64'(fop[base % 4]), 64'h9F);
    chk("R1 id frame length", 64'(flen[base % 4]), 64'd10);
    if (expfr == 2) begin
      chk("R6 sn opcode", 64'(fop[(base + 1) % 4]), 64'hC3);
      chk("R6 sn frame length", 64'(flen[(base + 1) % 4]), 64'd9);
    end
    repeat (4) @(negedge clk);
    chk("R8 result held", {62'd0, id_valid, id_error}, {62'd0, ok, !ok});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 cs high", 64'(spi_cs_n), 64'd1);
    chk("R12 req low", 64'(bx_req), 64'd0);
    chk("R12 flags low", {62'd0, id_valid, id_error}, 64'd0);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] m, f;
      m = (c % 7 == 3) ? (8'hC2 ^ (8'h01 << (c % 8))) : 8'hC2;
      f = (c % 3 == 0) ? 8'h00 : 8'(c + 1);
      run_one(8'(c), m, f, c % 3, (c % 16 == 5));
    end
    for (int c = 'h21; c <= 'h26; c++) begin
      run_one(8'(c), 8'hC2, 8'h01, 2, 1'b1);
      run_one(8'(c), 8'hC2, 8'h80, 0, 1'b0);
    end
    run_one(8'h26, 8'h00, 8'hFF, 1, 1'b0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule